// File: doc/BRIEF.md
# Dissemination Barrier Synchronizer

This block lets a group of P participants (P a power of two, at least 2) wait for each other at a barrier. A participant announces that it has reached the barrier with a one-cycle arrive pulse. It then receives a one-cycle release pulse once every participant has reached the same barrier episode. No shared arrival counter exists anywhere in the block.

Completion is reached through log2(P) rounds of pairwise signalling. In round k, participant i writes a flag owned by participant (i + 2^k) mod P. It then waits until its own round-k flag, written by participant (i - 2^k) mod P, has been written. Every flag has exactly one writer and one reader, and both are fixed at design time. Each participant keeps a local sense bit, and the value written to a flag is the inverse of that bit. The sense bit flips after every release, so the flags left over from one episode are already stale for the next one and never need to be cleared.

Top module: `dissem_barrier`

## Requirements
- R1: No participant receives a release pulse for an episode before every participant has had an arrive pulse accepted for that episode.
- R2: Each participant receives exactly one release pulse per episode, and that pulse is high for a single cycle.
- R3: When all participants arrive on the same clock edge, every release pulse appears exactly 2·log2(P) cycles after that edge. Each round takes one cycle to send the signal and one cycle to test the flag.
- R4: Once the last participant of an episode has arrived, every participant is released within 4·log2(P)+2 cycles.
- R5: An arrive pulse from a participant that is waiting inside the barrier is ignored. It causes no extra release and does not disturb the episode in progress or the next one.
- R6: After its release, a participant returns to idle and may arrive again on the very next cycle. The episode that other participants are still finishing completes correctly.
- R7: After a synchronous active-low reset, all flags and sense bits are 0, every participant is idle in round 0, and the release output is 0.
- R8: The local sense of a participant inverts on every one of its releases, so that consecutive episodes reuse the same flags without a clearing pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arrive | input | P | One bit per participant; a high bit announces arrival at the barrier |
| release_o | output | P | One bit per participant; a one-cycle pulse when that participant may leave the barrier |

## Verification
The bench sweeps every combination of arrival delays from 0 to 3 cycles for four participants. On every other episode it also fires arrive on all lines while everyone is waiting. A design that released on a partial arrival set, or that read a flag left over from the previous episode because the sense was not inverted, would release too early or release twice. A design that honoured a mid-barrier arrive would produce a second release.

The bench also checks the exact latency for simultaneous arrival, and runs long back-to-back chains in which each participant re-arrives the cycle after its release. An off-by-one in the round counter would shift the release cycle. Letting a fresh arrival overwrite a flag that a slower neighbour still needs would stall an episode.

// File: rtl/dissem_barrier.sv
module dissem_barrier #(
  parameter int P = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] arrive,
  output logic [P-1:0] release_o
);

  localparam int L  = (P > 1) ? $clog2(P) : 1;
  localparam int RW = (L > 1) ? $clog2(L) : 1;

  logic [P-1:0]  busy;
  logic [P-1:0]  sent;
  logic [P-1:0]  sense;
  logic [RW-1:0] rnd [P];
  logic [L-1:0]  flg [P];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= '0;
      sent      <= '0;
      sense     <= '0;
      release_o <= '0;
      for (int i = 0; i < P; i++) begin
        rnd[i] <= '0;
        flg[i] <= '0;
      end
    end else begin
      for (int t = 0; t < P; t++) begin
        for (int k = 0; k < L; k++) begin
          int w;
          w = (t - (1 << k) + P) % P;
          if (busy[w] && !sent[w] && rnd[w] == RW'(k))
            flg[t][k] <= ~sense[w];
        end
      end
      for (int i = 0; i < P; i++) begin
        release_o[i] <= 1'b0;
        if (!busy[i]) begin
          if (arrive[i]) begin
            busy[i] <= 1'b1;
            sent[i] <= 1'b0;
            rnd[i]  <= '0;
          end
        end else if (!sent[i]) begin
          sent[i] <= 1'b1;
        end else if (flg[i][rnd[i]] == ~sense[i]) begin
          sent[i] <= 1'b0;
          if (rnd[i] == RW'(L - 1)) begin
            busy[i]      <= 1'b0;
            sense[i]     <= ~sense[i];
            release_o[i] <= 1'b1;
            rnd[i]       <= '0;
          end else begin
            rnd[i] <= rnd[i] + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dissem_barrier_chk.sv
module dissem_barrier_chk #(
  parameter int P = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [P-1:0] arrive,
  input logic [P-1:0] release_o,
  input logic [P-1:0] busy,
  input logic [P-1:0] sense
);

  logic [3:0] acc [P];
  logic [3:0] rel [P];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < P; i++) begin
        acc[i] <= '0;
        rel[i] <= '0;
      end
    end else begin
      for (int i = 0; i < P; i++) begin
        if (arrive[i] && !busy[i]) acc[i] <= acc[i] + 4'd1;
        if (release_o[i])          rel[i] <= rel[i] + 4'd1;
      end
    end
  end

  for (genvar i = 0; i < P; i++) begin : g_i
    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_o[i] |=> !release_o[i]);
    // R8
    sense_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_o[i] |-> sense[i] != $past(sense[i]));
    // R6
    back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_o[i] |-> $past(busy[i]) && !busy[i]);
    for (genvar j = 0; j < P; j++) begin : g_j
      // R1
      all_arrived_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_o[i] |-> acc[j] != rel[i]);
    end
  end

endmodule

bind dissem_barrier dissem_barrier_chk #(.P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .arrive(arrive),
  .release_o(release_o), .busy(busy), .sense(sense)
);

// File: tb/sim_dissem_barrier.sv
module sim_dissem_barrier;
  localparam int P = 4;
  localparam int L = 2;
  localparam int BOUND = 4 * L + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0] arrive = '0;
  logic [P-1:0] release_o;

  int cyc = 0;
  int nchk = 0;
  int nbad = 0;
  int tot [P];
  int lastrel [P];
  logic [P-1:0] prev = '0;

  always #5 clk = ~clk;

  dissem_barrier #(.P(P)) u0 (.clk(clk), .rst_n(rst_n), .arrive(arrive), .release_o(release_o));

  always @(posedge clk) cyc <= cyc + 1;

  initial for (int i = 0; i < P; i++) begin tot[i] = 0; lastrel[i] = 0; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < P; i++) begin
        if (release_o[i]) begin
          tot[i]++;
          lastrel[i] = cyc;
          if (prev[i]) check(0, "R2 pulse width", 2, 1);
        end
      end
    end
    prev = release_o;
  end

  task automatic episode(input int n, input bit spur);
    int d [P];
    int maxd, base, last_edge;
    int t0 [P];
    maxd = 0;
    for (int i = 0; i < P; i++) begin
      d[i] = (n >> (2 * i)) & 3;
      if (d[i] > maxd) maxd = d[i];
      t0[i] = tot[i];
    end
    base = cyc;
    last_edge = base + maxd + 1;
    for (int s = 0; s <= maxd + 1; s++) begin
      for (int i = 0; i < P; i++) arrive[i] = (d[i] == s);
      if (spur && s == maxd + 1) arrive = '1;
      @(negedge clk);
    end
    arrive = '0;
    repeat (BOUND + 2) @(negedge clk);
    for (int i = 0; i < P; i++) begin
      check(tot[i] - t0[i] == 1, spur ? "R5 single release" : "R2 single release", tot[i] - t0[i], 1);
      check(lastrel[i] > last_edge, "R1 release after last arrival", lastrel[i], last_edge + 1);
      check(lastrel[i] - last_edge <= BOUND, "R4 latency bound", lastrel[i] - last_edge, BOUND);
      if (n == 0) check(lastrel[i] == base + 1 + 2 * L, "R3 exact latency", lastrel[i] - base - 1, 2 * L);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: release low in reset and after
    check(release_o == '0, "R7 reset release", int'(release_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(release_o == '0, "R7 idle release", int'(release_o), 0);
    // R1: partial arrival never releases
    begin
      int t0 [P];
      for (int i = 0; i < P; i++) t0[i] = tot[i];
      arrive = 4'b0111;
      @(negedge clk);
      arrive = '0;
      repeat (20) @(negedge clk);
      for (int i = 0; i < P; i++)
        check(tot[i] == t0[i], "R1 partial arrival", tot[i] - t0[i], 0);
      arrive = 4'b1000;
      @(negedge clk);
      arrive = '0;
      repeat (BOUND + 2) @(negedge clk);
      for (int i = 0; i < P; i++)
        check(tot[i] - t0[i] == 1, "R1 completion", tot[i] - t0[i], 1);
    end
    // R8: sweep of all delay patterns across consecutive episodes
    for (int n = 0; n < (1 << (2 * P)); n++) episode(n, n[0]);
    // R6: back-to-back re-arrival on the cycle after release
    begin
      int t0 [P];
      int start;
      for (int i = 0; i < P; i++) t0[i] = tot[i];
      arrive = '1;
      start = cyc;
      @(negedge clk);
      arrive = '0;
      for (int e = 1; e <= 20; e++) begin
        int w;
        w = 0;
        while (release_o == '0 && w < 50) begin @(negedge clk); w++; end
        check(release_o == '1, "R6 joint release", int'(release_o), 15);
        check(cyc == start + e * (2 * L + 1), "R6 period", cyc - start, e * (2 * L + 1));
        if (e < 20) arrive = release_o;
        @(negedge clk);
        arrive = '0;
      end
      repeat (BOUND) @(negedge clk);
      for (int i = 0; i < P; i++)
        check(tot[i] - t0[i] == 20, "R6 episode count", tot[i] - t0[i], 20);
    end
    // R6: staggered back-to-back, participant 0 re-arrives alone first
    begin
      int t0 [P];
      for (int i = 0; i < P; i++) t0[i] = tot[i];
      for (int e = 0; e < 10; e++) begin
        arrive = 4'b0001;
        @(negedge clk);
        arrive = 4'b1110;
        @(negedge clk);
        arrive = '0;
        while (release_o[0] == 1'b0) @(negedge clk);
        arrive = 4'b0001;
        @(negedge clk);
        arrive = '0;
        repeat (BOUND + 2) @(negedge clk);
        arrive = 4'b1110;
        @(negedge clk);
        arrive = '0;
        repeat (BOUND + 2) @(negedge clk);
      end
      for (int i = 0; i < P; i++)
        check(tot[i] - t0[i] == 20, "R6 staggered count", tot[i] - t0[i], 20);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

endmodule